// File: doc/BRIEF.md
# Platform Sleep-State Power Sequencer

This block walks a processor platform between its mechanical-off (G3), soft-off (S5), suspend-to-RAM (S3) and working (S0) power states. It drives the enables of the board rails, the power-good indications handed to the chipset, the peripheral resets, a CPU throttle line and a wireless state code. It watches the rail power-good inputs and the chipset's active-low sleep indications. Every move between two stable states passes through a transition sequence of its own. Each sequence has an ordered series of rail steps and fixed settle delays. Where a sequence waits on a rail, it rolls back if the rail does not arrive within a timeout.

A single down-counter, clocked by a microsecond tick derived from the system clock, times every delay and every timeout. All power-good, sleep and wake inputs are resynchronized through two flops before the state machine sees them. A configuration bit decides whether a shutdown from S3 stops in S5 or continues to G3. A 3-bit status output reports where the sequencer is.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the block is in G3 with every enable, power-good output, reset output and the throttle low, and the wireless code OFF (0). In G3 a high `wake_req` starts the G3-to-S5 sequence.
- R2: `pstate` reports 0 in G3, 1 in S5, 2 in S3, 3 in S0, 4 in any power-up transition and 5 in any power-down transition. No other value appears.
- R3: G3-to-S5 runs in this order, with each step waiting for the previous one:
  - enable the deep-sleep 3.3 V rail and wait `T_DSW_US`;
  - enable 5 V and wait until the 1.05 V and 1.2 V power-goods both read low, which means 5 V is stable;
  - enable the gated 3.3 V rail, raise `deep_pwr_ok` and enable 1.05 V;
  - wait for the 1.05 V power-good high together with `sl_aux_n` high;
  - wait `T_AUX_US` and enter S5.
- R4: If the 5 V check does not pass within `T_5V_TO_US`, or the 1.05 V/auxiliary wait does not pass within `T_PG_TO_US`, every output is cleared and the block returns to G3.
- R5: In S5, `sl_s5_n` high starts S5-to-S3. This enables the 1.8 V and 1.2 V rails and waits for both power-goods. It then releases the lightbar reset. One step later it enables touchpad and USB 5 V power and enters S3.
- R6: If the memory rails do not report good within `T_PG_TO_US`, both are disabled, `deep_pwr_ok` drops, and the block returns to S5.
- R7: In S3 three checks apply, in this priority:
  - loss of the 1.2 V or 1.8 V power-good drops `deep_pwr_ok` and starts the S3-to-S5 sequence;
  - otherwise `sl_s3_n` high starts S3-to-S0;
  - otherwise `sl_s5_n` low starts S3-to-S5.
- R8: S3-to-S0 runs in this order:
  - wait `T_VCCST_US`;
  - set the wireless code ON (2) and release the touchscreen reset;
  - wait for the 1.05 V power-good;
  - wait `T_PWROK_US`;
  - copy `throttle_req` to `thr_out` and raise both `plat_pwr_ok` and `sys_pwr_ok`, on entry to S0.
- R9: If the 1.05 V power-good does not arrive within `T_PG_TO_US` during S3-to-S0, `deep_pwr_ok` drops, the wireless code goes OFF, and the block returns to S3.
- R10: In S0, loss of the 1.05 V power-good (which also drops `deep_pwr_ok`) or `sl_s3_n` low starts S0-to-S3. That sequence drops both platform power-goods, then one cycle later sets the wireless code SUSPEND (1), lowers `thr_out` and enters S3.
- R11: While in S0, `thr_out` follows `throttle_req` with one cycle of latency. Outside S0 and the S0-to-S3 sequence it is low.
- R12: S3-to-S5 first turns wireless OFF and disables touchpad, USB, 1.8 V and 1.2 V power. One cycle later it asserts the touchscreen and lightbar resets. It then enters S5 if `pause_s5` is high, and starts S5-to-G3 otherwise.
- R13: S5-to-G3 drops `deep_pwr_ok`. One cycle later it disables 1.05 V, gated 3.3 V, 5 V and deep-sleep 3.3 V, and enters G3 with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req | input | 1 | Power-on request, honoured in G3 |
| pause_s5 | input | 1 | Stop in S5 when shutting down from S3 |
| throttle_req | input | 1 | Requested CPU throttle level |
| pg_1v05 | input | 1 | 1.05 V rail power-good |
| pg_1v2 | input | 1 | 1.2 V memory rail power-good |
| pg_1v8 | input | 1 | 1.8 V memory rail power-good |
| sl_s3_n | input | 1 | Chipset S3 sleep indication, active low |
| sl_s5_n | input | 1 | Chipset S5 sleep indication, active low |
| sl_aux_n | input | 1 | Chipset auxiliary-well sleep indication, active low |
| en_dsw | output | 1 | Deep-sleep 3.3 V rail enable |
| en_5v | output | 1 | 5 V rail enable |
| en_dsw_gated | output | 1 | Gated 3.3 V rail enable |
| en_1v05 | output | 1 | 1.05 V rail enable |
| en_1v2 | output | 1 | 1.2 V rail enable |
| en_1v8 | output | 1 | 1.8 V rail enable |
| en_usb5v | output | 1 | USB 5 V power enable |
| en_touchpad | output | 1 | Touchpad power enable |
| tsc_rst_n | output | 1 | Touchscreen reset, active low |
| lbar_rst_n | output | 1 | Lightbar reset, active low |
| deep_pwr_ok | output | 1 | Deep-sleep well power-good to chipset |
| plat_pwr_ok | output | 1 | Platform power-good to chipset |
| sys_pwr_ok | output | 1 | System power-good |
| thr_out | output | 1 | CPU throttle output |
| wl_state | output | 2 | Wireless code: 0 OFF, 1 SUSPEND, 2 ON |
| pstate | output | 3 | Status code as in R2 |

## Verification
The hardest situations to reach from the ports are the rollback paths. A sleep input that stays deasserted makes the block re-enter the failing sequence on the very next cycle. The stimulus therefore holds the rail input at its failing level and waits until the status reads 4. Only then does it withdraw the sleep request, so the block lands back in its stable state once and stays there. The S3 priority is exercised by removing the 1.8 V power-good and raising `sl_s3_n` on the same clock, which must give a power-down and not a power-up.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [4:0] {
    P_G3, P_S5, P_S3, P_S0,
    U_DSW, U_5V, U_AUX, U_AUXCLK, U_RAM, U_PERIPH, U_VCCST, U_CORE, U_PWROK,
    D_WLSUSP, D_RAILS, D_RESETS, D_DEEP, D_OFF
  } seq_e;

  typedef struct packed {
    logic       dsw;
    logic       v5;
    logic       dswg;
    logic       v1p05;
    logic       v1p2;
    logic       v1p8;
    logic       usb;
    logic       tpad;
    logic       tsc_rst_n;
    logic       lbar_rst_n;
    logic       deep_ok;
    logic       plat_ok;
    logic       sys_ok;
    logic       thr;
    logic [1:0] wl;
  } ctl_t;

  localparam logic [1:0] WL_OFF  = 2'd0;
  localparam logic [1:0] WL_SUSP = 2'd1;
  localparam logic [1:0] WL_ON   = 2'd2;

  localparam logic [2:0] PS_G3   = 3'd0;
  localparam logic [2:0] PS_S5   = 3'd1;
  localparam logic [2:0] PS_S3   = 3'd2;
  localparam logic [2:0] PS_S0   = 3'd3;
  localparam logic [2:0] PS_UP   = 3'd4;
  localparam logic [2:0] PS_DOWN = 3'd5;

  // input bit positions after synchronization
  localparam int IX_WAKE = 0;
  localparam int IX_P105 = 1;
  localparam int IX_P12  = 2;
  localparam int IX_P18  = 3;
  localparam int IX_S3N  = 4;
  localparam int IX_S5N  = 5;
  localparam int IX_AUXN = 6;
  localparam int N_IN    = 7;

  function automatic logic [2:0] code_of(seq_e s);
    case (s)
      P_G3:    return PS_G3;
      P_S5:    return PS_S5;
      P_S3:    return PS_S3;
      P_S0:    return PS_S0;
      U_DSW, U_5V, U_AUX, U_AUXCLK, U_RAM, U_PERIPH,
      U_VCCST, U_CORE, U_PWROK: return PS_UP;
      default: return PS_DOWN;
    endcase
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CLK_PER_US = 25,
  parameter int TW         = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [PW-1:0] pre_q;
  logic [TW-1:0] cnt_q;
  logic          tick;

  assign tick    = (pre_q == PW'(CLK_PER_US - 1));
  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      cnt_q <= load_val;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int TW          = 20,
  parameter int T_DSW_US    = 10000,
  parameter int T_AUX_US    = 5000,
  parameter int T_VCCST_US  = 20000,
  parameter int T_PWROK_US  = 99000,
  parameter int T_5V_TO_US  = 1000000,
  parameter int T_PG_TO_US  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   in_s,
  input  logic              pause_s5,
  input  logic              throttle_req,
  input  logic              tmr_exp,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output ctl_t              ctl,
  output logic [2:0]        pstate
);
  seq_e st_q, nst;
  ctl_t ctl_q, nctl;

  logic wake, p105, p12, p18, s3n, s5n, auxn;
  assign wake = in_s[IX_WAKE];
  assign p105 = in_s[IX_P105];
  assign p12  = in_s[IX_P12];
  assign p18  = in_s[IX_P18];
  assign s3n  = in_s[IX_S3N];
  assign s5n  = in_s[IX_S5N];
  assign auxn = in_s[IX_AUXN];

  always_comb begin
    nst      = st_q;
    nctl     = ctl_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      P_G3: if (wake) begin
        nctl.dsw = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(T_DSW_US);
        nst = U_DSW;
      end
      U_DSW: if (tmr_exp) begin
        nctl.v5  = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(T_5V_TO_US);
        nst = U_5V;
      end
      U_5V: begin
        if (!p105 && !p12) begin
          nctl.dswg    = 1'b1;
          nctl.deep_ok = 1'b1;
          nctl.v1p05   = 1'b1;
          tmr_load = 1'b1; tmr_val = TW'(T_PG_TO_US);
          nst = U_AUX;
        end else if (tmr_exp) begin
          nctl = '0;
          nst  = P_G3;
        end
      end
      U_AUX: begin
        if (p105 && auxn) begin
          tmr_load = 1'b1; tmr_val = TW'(T_AUX_US);
          nst = U_AUXCLK;
        end else if (tmr_exp) begin
          nctl = '0;
          nst  = P_G3;
        end
      end
      U_AUXCLK: if (tmr_exp) nst = P_S5;
      P_S5: if (s5n) begin
        nctl.v1p8 = 1'b1;
        nctl.v1p2 = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(T_PG_TO_US);
        nst = U_RAM;
      end
      U_RAM: begin
        if (p12 && p18) begin
          nctl.lbar_rst_n = 1'b1;
          nst = U_PERIPH;
        end else if (tmr_exp) begin
          nctl.v1p2    = 1'b0;
          nctl.v1p8    = 1'b0;
          nctl.deep_ok = 1'b0;
          nst = P_S5;
        end
      end
      U_PERIPH: begin
        nctl.tpad = 1'b1;
        nctl.usb  = 1'b1;
        nst = P_S3;
      end
      P_S3: begin
        if (!(p12 && p18)) begin
          nctl.deep_ok = 1'b0;
          nst = D_RAILS;
        end else if (s3n) begin
          tmr_load = 1'b1; tmr_val = TW'(T_VCCST_US);
          nst = U_VCCST;
        end else if (!s5n) begin
          nst = D_RAILS;
        end
      end
      U_VCCST: if (tmr_exp) begin
        nctl.wl        = WL_ON;
        nctl.tsc_rst_n = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(T_PG_TO_US);
        nst = U_CORE;
      end
      U_CORE: begin
        if (p105) begin
          tmr_load = 1'b1; tmr_val = TW'(T_PWROK_US);
          nst = U_PWROK;
        end else if (tmr_exp) begin
          nctl.deep_ok = 1'b0;
          nctl.wl      = WL_OFF;
          nst = P_S3;
        end
      end
      U_PWROK: if (tmr_exp) begin
        nctl.thr     = throttle_req;
        nctl.plat_ok = 1'b1;
        nctl.sys_ok  = 1'b1;
        nst = P_S0;
      end
      P_S0: begin
        nctl.thr = throttle_req;
        if (!p105) begin
          nctl.deep_ok = 1'b0;
          nctl.plat_ok = 1'b0;
          nctl.sys_ok  = 1'b0;
          nst = D_WLSUSP;
        end else if (!s3n) begin
          nctl.plat_ok = 1'b0;
          nctl.sys_ok  = 1'b0;
          nst = D_WLSUSP;
        end
      end
      D_WLSUSP: begin
        nctl.wl  = WL_SUSP;
        nctl.thr = 1'b0;
        nst = P_S3;
      end
      D_RAILS: begin
        nctl.wl   = WL_OFF;
        nctl.tpad = 1'b0;
        nctl.usb  = 1'b0;
        nctl.v1p8 = 1'b0;
        nctl.v1p2 = 1'b0;
        nst = D_RESETS;
      end
      D_RESETS: begin
        nctl.tsc_rst_n  = 1'b0;
        nctl.lbar_rst_n = 1'b0;
        nst = pause_s5 ? P_S5 : D_DEEP;
      end
      D_DEEP: begin
        nctl.deep_ok = 1'b0;
        nst = D_OFF;
      end
      D_OFF: begin
        nctl.v1p05 = 1'b0;
        nctl.dswg  = 1'b0;
        nctl.v5    = 1'b0;
        nctl.dsw   = 1'b0;
        nst = P_G3;
      end
      default: begin
        nctl = '0;
        nst  = P_G3;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= P_G3;
      ctl_q <= '0;
    end else begin
      st_q  <= nst;
      ctl_q <= nctl;
    end
  end

  assign ctl    = ctl_q;
  assign pstate = code_of(st_q);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int CLK_PER_US  = 25,
  parameter int T_DSW_US    = 10000,
  parameter int T_AUX_US    = 5000,
  parameter int T_VCCST_US  = 20000,
  parameter int T_PWROK_US  = 99000,
  parameter int T_5V_TO_US  = 1000000,
  parameter int T_PG_TO_US  = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_req,
  input  logic       pause_s5,
  input  logic       throttle_req,
  input  logic       pg_1v05,
  input  logic       pg_1v2,
  input  logic       pg_1v8,
  input  logic       sl_s3_n,
  input  logic       sl_s5_n,
  input  logic       sl_aux_n,
  output logic       en_dsw,
  output logic       en_5v,
  output logic       en_dsw_gated,
  output logic       en_1v05,
  output logic       en_1v2,
  output logic       en_1v8,
  output logic       en_usb5v,
  output logic       en_touchpad,
  output logic       tsc_rst_n,
  output logic       lbar_rst_n,
  output logic       deep_pwr_ok,
  output logic       plat_pwr_ok,
  output logic       sys_pwr_ok,
  output logic       thr_out,
  output logic [1:0] wl_state,
  output logic [2:0] pstate
);
  localparam int T_MAX = max2(max2(max2(T_DSW_US, T_AUX_US), max2(T_VCCST_US, T_PWROK_US)),
                              max2(T_5V_TO_US, T_PG_TO_US));
  localparam int TW = $clog2(T_MAX + 1);

  logic [N_IN-1:0] raw_in, syn_in;
  logic            tmr_load, tmr_exp;
  logic [TW-1:0]   tmr_val;
  ctl_t            ctl;

  always_comb begin
    raw_in          = '0;
    raw_in[IX_WAKE] = wake_req;
    raw_in[IX_P105] = pg_1v05;
    raw_in[IX_P12]  = pg_1v2;
    raw_in[IX_P18]  = pg_1v8;
    raw_in[IX_S3N]  = sl_s3_n;
    raw_in[IX_S5N]  = sl_s5_n;
    raw_in[IX_AUXN] = sl_aux_n;
  end

  pwr_seq_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  pwr_seq_timer #(.CLK_PER_US(CLK_PER_US), .TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  pwr_seq_fsm #(
    .TW(TW), .T_DSW_US(T_DSW_US), .T_AUX_US(T_AUX_US), .T_VCCST_US(T_VCCST_US),
    .T_PWROK_US(T_PWROK_US), .T_5V_TO_US(T_5V_TO_US), .T_PG_TO_US(T_PG_TO_US)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_s(syn_in), .pause_s5(pause_s5),
    .throttle_req(throttle_req), .tmr_exp(tmr_exp), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .ctl(ctl), .pstate(pstate)
  );

  assign en_dsw       = ctl.dsw;
  assign en_5v        = ctl.v5;
  assign en_dsw_gated = ctl.dswg;
  assign en_1v05      = ctl.v1p05;
  assign en_1v2       = ctl.v1p2;
  assign en_1v8       = ctl.v1p8;
  assign en_usb5v     = ctl.usb;
  assign en_touchpad  = ctl.tpad;
  assign tsc_rst_n    = ctl.tsc_rst_n;
  assign lbar_rst_n   = ctl.lbar_rst_n;
  assign deep_pwr_ok  = ctl.deep_ok;
  assign plat_pwr_ok  = ctl.plat_ok;
  assign sys_pwr_ok   = ctl.sys_ok;
  assign thr_out      = ctl.thr;
  assign wl_state     = ctl.wl;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_dsw,
  input logic       en_5v,
  input logic       en_dsw_gated,
  input logic       en_1v05,
  input logic       en_1v2,
  input logic       en_1v8,
  input logic       en_usb5v,
  input logic       en_touchpad,
  input logic       tsc_rst_n,
  input logic       lbar_rst_n,
  input logic       deep_pwr_ok,
  input logic       plat_pwr_ok,
  input logic       sys_pwr_ok,
  input logic       thr_out,
  input logic [1:0] wl_state,
  input logic [2:0] pstate
);
  logic [15:0] outs;
  assign outs = {en_dsw, en_5v, en_dsw_gated, en_1v05, en_1v2, en_1v8, en_usb5v,
                 en_touchpad, tsc_rst_n, lbar_rst_n, deep_pwr_ok, plat_pwr_ok,
                 sys_pwr_ok, thr_out, wl_state};

  p_g3_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 3'd0) |-> (outs == 16'h0000));

  p_state_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pstate <= 3'd5);

  p_leave_g3_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pstate) == 3'd0 && pstate != 3'd0) |-> (pstate == 3'd4));

  p_gated_under_5v_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_dsw_gated |-> (en_5v && en_dsw));

  p_pwrok_rails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    plat_pwr_ok |-> (en_1v05 && en_1v2 && en_1v8 && sys_pwr_ok));

  p_pwrok_rise_s0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plat_pwr_ok) |-> (pstate == 3'd3));

  p_wl_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wl_state != 2'd3);

  p_thr_scope_r11: assert property (@(posedge clk) disable iff (!rst_n)
    thr_out |-> (pstate == 3'd3 || pstate == 3'd5));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_dsw(en_dsw), .en_5v(en_5v),
  .en_dsw_gated(en_dsw_gated), .en_1v05(en_1v05), .en_1v2(en_1v2),
  .en_1v8(en_1v8), .en_usb5v(en_usb5v), .en_touchpad(en_touchpad),
  .tsc_rst_n(tsc_rst_n), .lbar_rst_n(lbar_rst_n), .deep_pwr_ok(deep_pwr_ok),
  .plat_pwr_ok(plat_pwr_ok), .sys_pwr_ok(sys_pwr_ok), .thr_out(thr_out),
  .wl_state(wl_state), .pstate(pstate)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K      = 2;
  localparam int T_DSW  = 10;
  localparam int T_AUX  = 5;
  localparam int T_VCC  = 20;
  localparam int T_PWR  = 9;
  localparam int T_5VTO = 40;
  localparam int T_PGTO = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_req = 0, pause_s5 = 0, throttle_req = 0;
  logic pg_1v05 = 0, pg_1v2 = 0, pg_1v8 = 0;
  logic sl_s3_n = 0, sl_s5_n = 0, sl_aux_n = 0;
  logic en_dsw, en_5v, en_dsw_gated, en_1v05, en_1v2, en_1v8, en_usb5v, en_touchpad;
  logic tsc_rst_n, lbar_rst_n, deep_pwr_ok, plat_pwr_ok, sys_pwr_ok, thr_out;
  logic [1:0] wl_state;
  logic [2:0] pstate;
  logic [15:0] obs;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(
    .CLK_PER_US(K), .T_DSW_US(T_DSW), .T_AUX_US(T_AUX), .T_VCCST_US(T_VCC),
    .T_PWROK_US(T_PWR), .T_5V_TO_US(T_5VTO), .T_PG_TO_US(T_PGTO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .pause_s5(pause_s5),
    .throttle_req(throttle_req), .pg_1v05(pg_1v05), .pg_1v2(pg_1v2), .pg_1v8(pg_1v8),
    .sl_s3_n(sl_s3_n), .sl_s5_n(sl_s5_n), .sl_aux_n(sl_aux_n),
    .en_dsw(en_dsw), .en_5v(en_5v), .en_dsw_gated(en_dsw_gated), .en_1v05(en_1v05),
    .en_1v2(en_1v2), .en_1v8(en_1v8), .en_usb5v(en_usb5v), .en_touchpad(en_touchpad),
    .tsc_rst_n(tsc_rst_n), .lbar_rst_n(lbar_rst_n), .deep_pwr_ok(deep_pwr_ok),
    .plat_pwr_ok(plat_pwr_ok), .sys_pwr_ok(sys_pwr_ok), .thr_out(thr_out),
    .wl_state(wl_state), .pstate(pstate)
  );

  assign obs = {en_dsw, en_5v, en_dsw_gated, en_1v05, en_1v2, en_1v8, en_usb5v,
                en_touchpad, tsc_rst_n, lbar_rst_n, deep_pwr_ok, plat_pwr_ok,
                sys_pwr_ok, thr_out, wl_state};

  typedef struct {
    logic [2:0]  code;
    bit          chk;
    logic [15:0] vec;
    int          mind;
    string       tag;
  } item_t;

  item_t exp_q[$];
  item_t cur;
  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int last_cyc = 0;
  logic [2:0] last_st = 3'd0;

  always @(posedge clk) cyc++;

  task automatic push(input logic [2:0] c, input bit k, input logic [15:0] v,
                      input int md, input string t);
    item_t it;
    it.code = c; it.chk = k; it.vec = v; it.mind = md; it.tag = t;
    exp_q.push_back(it);
  endtask

  // monitor: each change of the status code is compared with the next expected item
  always @(negedge clk) begin
    if (rst_n && pstate !== last_st) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected status change: actual %0d expected none", pstate);
      end else begin
        cur = exp_q.pop_front();
        checks++;
        if (pstate !== cur.code) begin
          fails++;
          $display("FAIL %s status: actual %0d expected %0d", cur.tag, pstate, cur.code);
        end
        if (cur.chk) begin
          checks++;
          if (obs !== cur.vec) begin
            fails++;
            $display("FAIL %s outputs: actual %h expected %h", cur.tag, obs, cur.vec);
          end
        end
        if (cur.mind > 0) begin
          checks++;
          if (cyc - last_cyc < cur.mind) begin
            fails++;
            $display("FAIL %s dwell: actual %0d expected >= %0d", cur.tag, cyc - last_cyc, cur.mind);
          end
        end
      end
      last_st  = pstate;
      last_cyc = cyc;
    end
  end

  task automatic wait_state(input logic [2:0] c, input string t);
    int n = 0;
    while (pstate !== c && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) begin
      checks++; fails++;
      $display("FAIL %s wait: actual %0d expected %0d", t, pstate, c);
    end
  endtask

  task automatic direct(input bit ok, input string t, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, a, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    direct(obs === 16'h0000, "R1 reset outputs", obs, 16'h0000);
    direct(pstate === 3'd0, "R1 reset status", {13'd0, pstate}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    direct(obs === 16'h0000 && pstate === 3'd0, "R1 idle without wake", obs, 16'h0000);

    // R4: 5 V never reported stable (1.05 V good stuck high) -> rollback to G3
    pg_1v05 = 1'b1;
    push(3'd4, 0, 16'h0, 0, "R4 up");
    push(3'd0, 1, 16'h0000, (T_DSW + T_5VTO) * K, "R4 rollback");
    wake_req = 1'b1; repeat (4) @(negedge clk); wake_req = 1'b0;
    wait_state(3'd4, "R4"); wait_state(3'd0, "R4");

    // R3: normal power-up, 5 V stable once both lines drop low
    pg_1v2 = 1'b1;
    push(3'd4, 0, 16'h0, 0, "R3 up");
    push(3'd1, 1, 16'hF020, (T_DSW + T_AUX) * K, "R3 S5");
    wake_req = 1'b1; repeat (4) @(negedge clk); wake_req = 1'b0;
    repeat (40) @(negedge clk);
    direct(en_5v === 1'b1 && en_1v05 === 1'b0 && deep_pwr_ok === 1'b0, "R3 5V wait", obs, 16'hC000);
    pg_1v05 = 1'b0; pg_1v2 = 1'b0;
    repeat (20) @(negedge clk);
    direct(en_1v05 === 1'b1 && deep_pwr_ok === 1'b1 && en_dsw_gated === 1'b1, "R3 core on", obs, 16'hF020);
    pg_1v05 = 1'b1; sl_aux_n = 1'b1;
    wait_state(3'd1, "R3");

    // R5: S5 -> S3
    pg_1v2 = 1'b1; pg_1v8 = 1'b1;
    push(3'd4, 0, 16'h0, 0, "R5 up");
    push(3'd2, 1, 16'hFF60, 0, "R5 S3");
    sl_s5_n = 1'b1;
    wait_state(3'd2, "R5");

    // R8: S3 -> S0 with throttle requested
    throttle_req = 1'b1;
    push(3'd4, 0, 16'h0, 0, "R8 up");
    push(3'd3, 1, 16'hFFFE, (T_VCC + T_PWR) * K, "R8 S0");
    sl_s3_n = 1'b1;
    wait_state(3'd3, "R8");
    throttle_req = 1'b0;
    repeat (2) @(negedge clk);
    direct(thr_out === 1'b0 && pstate === 3'd3, "R11 throttle follows", {15'd0, thr_out}, 16'd0);

    // R10: S0 -> S3 on sleep request
    push(3'd5, 0, 16'h0, 0, "R10 down");
    push(3'd2, 1, 16'hFFE1, 0, "R10 S3");
    sl_s3_n = 1'b0;
    wait_state(3'd2, "R10");
    repeat (2) @(negedge clk);
    direct(thr_out === 1'b0, "R11 low in S3", {15'd0, thr_out}, 16'd0);

    push(3'd4, 0, 16'h0, 0, "R8 up again");
    push(3'd3, 1, 16'hFFFA, 0, "R8 S0 no throttle");
    sl_s3_n = 1'b1;
    wait_state(3'd3, "R8");

    // R10 rail loss in S0, then R9 timeout on the automatic retry
    push(3'd5, 0, 16'h0, 0, "R10 loss down");
    push(3'd2, 1, 16'hFFC1, 0, "R10 loss S3");
    push(3'd4, 0, 16'h0, 0, "R9 retry");
    push(3'd2, 1, 16'hFFC0, T_VCC * K, "R9 rollback");
    pg_1v05 = 1'b0;
    wait_state(3'd4, "R9");
    sl_s3_n = 1'b0;
    wait_state(3'd2, "R9");

    // R7 priority + R12 pause: 1.8 V lost while S3 sleep deasserts
    pause_s5 = 1'b1;
    push(3'd5, 0, 16'h0, 0, "R7 down");
    push(3'd1, 1, 16'hF000, 0, "R12 paused S5");
    pg_1v8 = 1'b0; sl_s3_n = 1'b1; sl_s5_n = 1'b0;
    wait_state(3'd1, "R7");
    sl_s3_n = 1'b0;

    // R6: memory rails time out
    push(3'd4, 0, 16'h0, 0, "R6 up");
    push(3'd1, 1, 16'hF000, T_PGTO * K, "R6 rollback");
    sl_s5_n = 1'b1;
    wait_state(3'd4, "R6");
    sl_s5_n = 1'b0;
    wait_state(3'd1, "R6");

    // R5 again with deep power-good already dropped
    pg_1v8 = 1'b1;
    push(3'd4, 0, 16'h0, 0, "R5 up2");
    push(3'd2, 1, 16'hFF40, 0, "R5 S3 2");
    sl_s5_n = 1'b1;
    wait_state(3'd2, "R5");

    // R12 + R13: no pause, all the way to G3
    pause_s5 = 1'b0;
    push(3'd5, 0, 16'h0, 0, "R12 down");
    push(3'd0, 1, 16'h0000, 0, "R13 G3");
    sl_s5_n = 1'b0;
    wait_state(3'd0, "R13");

    repeat (5) @(negedge clk);
    direct(exp_q.size() == 0, "R2 all transitions seen", 16'(exp_q.size()), 16'd0);
    finish_run();
  end
endmodule